// File: doc/BRIEF.md
# Two-Wire Serial Byte Shifter

This block is the byte data path of a two-wire serial interface. A CPU reaches it through four byte-wide register slots. A single shift register serves as both the CPU data register and the bus shifter. It sends the next byte most significant bit first, one bit per serial clock period. On each period it also captures the level actually present on the data line. When the byte ends, the register therefore holds what the bus carried, even if another driver won arbitration partway through.

A ninth clock carries the acknowledge bit, which the hardware drives and samples without CPU involvement. After that ninth clock an interrupt flag is raised. While the flag is raised the shifter is idle and holds the clock line low, and only then does the CPU get write access to the data register. Writing the start bit of the control slot clears the flag, latches the transfer direction and acknowledge policy, and launches the next byte.

A status slot combines a five-bit code, a reserved zero bit and a two-bit prescaler select. The code is supplied by an external sequencer and is captured when the flag is raised. The prescaler select stretches each quarter of the serial clock period by 1, 4, 16 or 64. Data line driving is open-drain: the output enable means "pull low".

Top module: `twi_byte_shift`

## Requirements
- R1: After reset the data slot (address 0) reads 0xFF, the status slot (address 1) reads 0xF8, the control slot (address 2) reads 0x00, `irq_o` is low, `sda_oe_o` is low and `scl_o` is high. An asynchronous reset applied in the middle of a byte returns all of these values at once.
- R2: A CPU write to the data slot is accepted only while the interrupt flag is set. At any other time, including before the first byte and while a byte is shifting, the write is ignored.
- R3: Writing the control slot with bit 7 = 1 while no byte is shifting clears the flag and starts a byte. Bit 1 = 1 selects transmit and bit 0 = 1 enables acknowledge driving in receive. Control reads return {flag, 00000, transmit, ack-enable}. Start writes made while a byte is shifting are ignored, and a control write with bit 7 = 0 has no effect.
- R4: Bits leave most significant first, one per serial clock period, and the data line is sampled while the clock is high. A transmitter pulls the data line low only for 0 bits. `sda_oe_o` changes only while `scl_o` is low.
- R5: Each period shifts the sampled line level into the register. After a byte in either direction, the data slot equals the eight bits seen on the bus.
- R6: The flag (`irq_o`, control bit 7) rises after the ninth clock of each byte. From then on `scl_o` stays low and the data slot holds its value, except for an accepted CPU write.
- R7: On the ninth clock a receiver with acknowledge enabled pulls the data line low, and in all other cases the block releases it. The sampled ninth bit appears on `nack_o` (1 = not acknowledged) and never enters the data slot.
- R8: If the block releases the line for a data bit but samples it low, `arb_lost_o` rises and stays high until the next start. The block drives no further data bits but keeps shifting bus bits in.
- R9: Status slot bits 7..3 hold the code taken from `sts_code_i` when the flag rises, and reset to 11111. Bit 2 always reads 0. Bits 1..0 are the read/write prescaler select, and writes to bits 7..2 are ignored.
- R10: The serial clock high time is 2 x QTR_CYC x {1, 4, 16, 64} clock cycles for prescaler select 00, 01, 10, 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_addr_i | input | 2 | Slot select: 0 data, 1 status, 2 control, 3 unused |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data for the selected slot |
| sts_code_i | input | 5 | Status code captured when the flag rises |
| sda_i | input | 1 | Sampled level of the data line |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| scl_o | output | 1 | Serial clock level |
| irq_o | output | 1 | Interrupt flag |
| nack_o | output | 1 | Last sampled acknowledge bit, 1 = not acknowledged |
| arb_lost_o | output | 1 | Arbitration lost during the current or last byte |

## Verification
The bench builds the block with QTR_CYC = 1, so one quarter period lasts a single clock at prescaler select 00. At that setting every shifting, acknowledge and arbitration case is run at full rate. Even at divide-by-64, a whole byte lasts only about 2300 cycles, so the serial clock high time can be measured at all four select values. A wired-AND bus model with a peer driver lets the bench compare the bits captured on each serial clock rise against the data register. It also lets the bench force arbitration loss mid-byte.

// File: rtl/twi_shift_pkg.sv
package twi_shift_pkg;
  localparam int BYTE_W = 8;
  localparam int STS_W  = 5;
  localparam int PSEL_W = 2;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CTRL_GO_BIT    = 7;
  localparam int CTRL_XMIT_BIT  = 1;
  localparam int CTRL_ACKEN_BIT = 0;
endpackage

// File: rtl/twi_quarter_tick.sv
module twi_quarter_tick
  import twi_shift_pkg::*;
#(
  parameter int QTR_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              tick_o
);
  localparam int MAX_LIM = QTR_CYC * 64;
  localparam int CW      = $clog2(MAX_LIM + 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit  = CW'(QTR_CYC) << {psel_i, 1'b0};
    tick_o = run_i && (cnt_q >= limit - CW'(1));
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_tick_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_i) && $stable(psel_i)) |-> (cnt_q < limit));
endmodule

// File: rtl/twi_bit_engine.sv
module twi_bit_engine
  import twi_shift_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         xmit_i,
  input  logic         ack_en_i,
  input  logic         tick_i,
  input  logic         load_en_i,
  input  logic [W-1:0] load_data_i,
  input  logic         sda_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] data_o,
  output logic         sda_oe_o,
  output logic         scl_o,
  output logic         nack_o,
  output logic         arb_lost_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic             busy_q, busy_d;
  logic [1:0]       phase_q, phase_d;
  logic [CNT_W-1:0] bitcnt_q, bitcnt_d;
  logic [W-1:0]     shreg_q, shreg_d;
  logic             samp_q, samp_d;
  logic             nack_q, nack_d;
  logic             arb_q, arb_d;
  logic             hold_q, hold_d;
  logic             last_bit;

  assign last_bit = (bitcnt_q == CNT_W'(W));

  always_comb begin
    busy_d   = busy_q;
    phase_d  = phase_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    samp_d   = samp_q;
    nack_d   = nack_q;
    arb_d    = arb_q;
    hold_d   = hold_q;
    done_o   = 1'b0;
    if (start_i && !busy_q) begin
      busy_d   = 1'b1;
      phase_d  = 2'd0;
      bitcnt_d = '0;
      arb_d    = 1'b0;
    end else if (busy_q && tick_i) begin
      phase_d = phase_q + 2'd1;
      unique case (phase_q)
        2'd2: begin
          samp_d = sda_i;
          if (last_bit) nack_d = sda_i;
          else if (xmit_i && shreg_q[W-1] && !sda_i) arb_d = 1'b1;
        end
        2'd3: begin
          if (last_bit) begin
            busy_d = 1'b0;
            hold_d = 1'b1;
            done_o = 1'b1;
          end else begin
            shreg_d  = {shreg_q[W-2:0], samp_q};
            bitcnt_d = bitcnt_q + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
    if (load_en_i && !busy_q) shreg_d = load_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      phase_q  <= 2'd0;
      bitcnt_q <= '0;
      shreg_q  <= '1;
      samp_q   <= 1'b1;
      nack_q   <= 1'b0;
      arb_q    <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      phase_q  <= phase_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      samp_q   <= samp_d;
      nack_q   <= nack_d;
      arb_q    <= arb_d;
      hold_q   <= hold_d;
    end
  end

  always_comb begin
    sda_oe_o = busy_q &&
      ((!last_bit && xmit_i && !arb_q && !shreg_q[W-1]) ||
       (last_bit && !xmit_i && ack_en_i));
    scl_o = busy_q ? phase_q[1] : !hold_q;
  end

  assign busy_o     = busy_q;
  assign data_o     = shreg_q;
  assign nack_o     = nack_q;
  assign arb_lost_o = arb_q;

  p_sda_moves_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_o);
  p_loss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arb_q |-> !sda_oe_o);
  p_bitcnt_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt_q <= CNT_W'(W));
  p_done_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_q && !scl_o));
endmodule

// File: rtl/twi_cpu_regs.sv
module twi_cpu_regs
  import twi_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [STS_W-1:0]  sts_code_i,
  output logic              start_o,
  output logic              load_en_o,
  output logic              xmit_o,
  output logic              ack_en_o,
  output logic [PSEL_W-1:0] psel_o,
  output logic              flag_o
);
  logic              flag_q, flag_d;
  logic              xmit_q, xmit_d;
  logic              acken_q, acken_d;
  logic [PSEL_W-1:0] psel_q, psel_d;
  logic [STS_W-1:0]  sts_q, sts_d;

  always_comb begin
    start_o   = wr_i && (addr_i == REG_CTRL) && wdata_i[CTRL_GO_BIT] && !busy_i;
    load_en_o = wr_i && (addr_i == REG_DATA) && flag_q;
    flag_d  = flag_q;
    xmit_d  = xmit_q;
    acken_d = acken_q;
    psel_d  = psel_q;
    sts_d   = sts_q;
    if (done_i) begin
      flag_d = 1'b1;
      sts_d  = sts_code_i;
    end else if (start_o) begin
      flag_d  = 1'b0;
      xmit_d  = wdata_i[CTRL_XMIT_BIT];
      acken_d = wdata_i[CTRL_ACKEN_BIT];
    end
    if (wr_i && (addr_i == REG_STAT)) psel_d = wdata_i[PSEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      xmit_q  <= 1'b0;
      acken_q <= 1'b0;
      psel_q  <= '0;
      sts_q   <= '1;
    end else begin
      flag_q  <= flag_d;
      xmit_q  <= xmit_d;
      acken_q <= acken_d;
      psel_q  <= psel_d;
      sts_q   <= sts_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_DATA: rdata_o = data_i;
      REG_STAT: rdata_o = {sts_q, 1'b0, psel_q};
      REG_CTRL: rdata_o = {flag_q, 5'b00000, xmit_q, acken_q};
      default:  rdata_o = '0;
    endcase
  end

  assign xmit_o   = xmit_q;
  assign ack_en_o = acken_q;
  assign psel_o   = psel_q;
  assign flag_o   = flag_q;

  p_flag_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> !busy_i);
  p_data_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && $past(flag_q) && !$past(load_en_o)) |-> $stable(data_i));
  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (!flag_q && busy_i));
endmodule

// File: rtl/twi_byte_shift.sv
module twi_byte_shift
  import twi_shift_pkg::*;
#(
  parameter int QTR_CYC = 5
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cpu_wr_i,
  input  logic [1:0]        cpu_addr_i,
  input  logic [BYTE_W-1:0] cpu_wdata_i,
  output logic [BYTE_W-1:0] cpu_rdata_o,
  input  logic [STS_W-1:0]  sts_code_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              scl_o,
  output logic              irq_o,
  output logic              nack_o,
  output logic              arb_lost_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic              start, load_en, xmit, ack_en, busy, done, tick;
  logic [PSEL_W-1:0] psel;
  logic [BYTE_W-1:0] data;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  twi_cpu_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_i(cpu_wr_i), .addr_i(cpu_addr_i), .wdata_i(cpu_wdata_i),
    .rdata_o(cpu_rdata_o), .busy_i(busy), .done_i(done), .data_i(data),
    .sts_code_i(sts_code_i), .start_o(start), .load_en_o(load_en),
    .xmit_o(xmit), .ack_en_o(ack_en), .psel_o(psel), .flag_o(irq_o)
  );

  twi_quarter_tick #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(busy), .psel_i(psel), .tick_o(tick)
  );

  twi_bit_engine #(.W(BYTE_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start), .xmit_i(xmit),
    .ack_en_i(ack_en), .tick_i(tick), .load_en_i(load_en),
    .load_data_i(cpu_wdata_i), .sda_i(sda_i), .busy_o(busy), .done_o(done),
    .data_o(data), .sda_oe_o(sda_oe_o), .scl_o(scl_o), .nack_o(nack_o),
    .arb_lost_o(arb_lost_o)
  );
endmodule

// File: tb/test_twi_byte_shift.sv
module test_twi_byte_shift;
  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic [4:0] sts_code = 5'h00;
  logic       sda_oe, scl, irq, nack, arb_lost;
  logic       peer_oe = 1'b0;
  wire        sda_line = ~(sda_oe | peer_oe);
  logic [8:0] bus_sh = '0;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cur_psel = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  twi_byte_shift #(.QTR_CYC(1)) i_twi_byte_shift (
    .clk(clk), .arst_n(arst_n), .cpu_wr_i(cpu_wr), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .sts_code_i(sts_code),
    .sda_i(sda_line), .sda_oe_o(sda_oe), .scl_o(scl), .irq_o(irq),
    .nack_o(nack), .arb_lost_o(arb_lost)
  );

  // bus capture on each serial clock rise, MSB first
  always @(posedge scl) bus_sh <= {bus_sh[7:0], sda_line};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // fields: xmit ack_en tx peer peer_ack exp_byte exp_nack exp_arb
  localparam logic [28:0] VEC [7] = '{
    {1'b0, 1'b1, 8'h00, 8'hA5, 1'b1, 8'hA5, 1'b0, 1'b0},
    {1'b0, 1'b0, 8'h00, 8'h3C, 1'b1, 8'h3C, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h96, 8'hFF, 1'b0, 8'h96, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h5A, 8'hFF, 1'b1, 8'h5A, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'hF0, 8'hB3, 1'b0, 8'hB3, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h81, 8'h81, 1'b1, 8'h81, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic run_byte(input logic [28:0] v, input logic [4:0] code,
                          input int hi_exp, input string tag);
    logic xm, ae, pa, en, ea;
    logic [7:0] tx, pb, eb, rd, snap;
    int n;
    int hcnt;
    {xm, ae, tx, pb, pa, eb, en, ea} = v;
    sts_code = code;
    if (xm) cpu_write(2'd0, tx);
    bus_sh = '0;
    peer_oe = ~pb[7];
    cpu_write(2'd2, {1'b1, 5'b00000, xm, ae});
    fork
      begin
        for (int i = 1; i <= 8; i++) begin
          @(negedge scl);
          peer_oe = (i == 8) ? ~pa : ~pb[7-i];
          if (hi_exp == 0 && i == 3) cpu_write(2'd0, 8'h00);
          if (hi_exp == 0 && i == 5) cpu_write(2'd2, 8'h80);
        end
      end
      begin
        if (hi_exp != 0) begin
          @(posedge scl);
          hcnt = 0;
          do begin
            @(posedge clk);
            #1 hcnt = hcnt + 1;
          end while (scl && hcnt < 1000);
          check({"R10 high time ", tag}, hcnt, hi_exp);
        end
      end
    join
    n = 0;
    while (!irq && n < 20000) begin
      @(posedge clk);
      n = n + 1;
    end
    check({"R6 flag raised ", tag}, {31'd0, irq}, 1);
    @(negedge clk);
    peer_oe = 1'b0;
    cpu_read(2'd0, rd);
    check({"R5 R2 data slot ", tag}, rd, eb);
    check({"R4 bus bits ", tag}, bus_sh[8:1], eb);
    check({"R7 ninth bit on bus ", tag}, bus_sh[0], en);
    check({"R7 nack_o ", tag}, nack, en);
    check({"R8 arb_lost_o ", tag}, arb_lost, ea);
    cpu_read(2'd1, rd);
    check({"R9 status ", tag}, rd, {code, 1'b0, 2'(cur_psel)});
    cpu_read(2'd2, rd);
    check({"R3 R6 control ", tag}, rd, {1'b1, 5'b00000, xm, ae});
    snap = eb;
    repeat (20) @(posedge clk);
    #1;
    check({"R6 scl held low ", tag}, scl, 1'b0);
    cpu_read(2'd0, rd);
    check({"R6 data stable ", tag}, rd, snap);
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset values while reset held
    check("R1 scl during reset", scl, 1'b1);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    cpu_read(2'd0, rd); check("R1 data reset", rd, 8'hFF);
    cpu_read(2'd1, rd); check("R1 status reset", rd, 8'hF8);
    cpu_read(2'd2, rd); check("R1 control reset", rd, 8'h00);
    check("R1 irq reset", irq, 1'b0);
    check("R1 sda_oe reset", sda_oe, 1'b0);
    check("R1 scl reset", scl, 1'b1);

    // R2 data write before first flag is ignored
    cpu_write(2'd0, 8'h12);
    cpu_read(2'd0, rd); check("R2 write before flag", rd, 8'hFF);

    // R9 status writes only touch prescaler bits
    cpu_write(2'd1, 8'hFF);
    cpu_read(2'd1, rd); check("R9 status write", rd, 8'hFB);
    cpu_write(2'd1, 8'h00);
    cpu_read(2'd1, rd); check("R9 status restore", rd, 8'hF8);

    // vector table
    for (int k = 0; k < 7; k++) begin
      run_byte(VEC[k], 5'(k + 3), 0, $sformatf("vec%0d", k));
    end

    // R3 control write without go bit leaves flag and mode
    cpu_write(2'd2, 8'h03);
    cpu_read(2'd2, rd); check("R3 no-go write", rd, 8'h82);

    // R2 accepted write while flag set
    cpu_write(2'd0, 8'hC7);
    cpu_read(2'd0, rd); check("R2 write with flag", rd, 8'hC7);

    // R10 prescaler high times
    for (int p = 1; p < 4; p++) begin
      cur_psel = p;
      cpu_write(2'd1, 8'(p));
      run_byte({1'b0, 1'b0, 8'h00, 8'h6E, 1'b1, 8'h6E, 1'b1, 1'b0},
               5'h11, 2 * (1 << (2 * p)), $sformatf("psel%0d", p));
    end
    cur_psel = 0;
    cpu_write(2'd1, 8'h00);

    // R1 asynchronous reset mid-byte
    peer_oe = 1'b0;
    cpu_write(2'd2, 8'h81);
    repeat (10) @(negedge clk);
    arst_n = 1'b0;
    #1;
    check("R1 mid reset scl", scl, 1'b1);
    check("R1 mid reset sda_oe", sda_oe, 1'b0);
    check("R1 mid reset irq", irq, 1'b0);
    cpu_read(2'd0, rd); check("R1 mid reset data", rd, 8'hFF);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    cpu_read(2'd1, rd); check("R1 status after reset", rd, 8'hF8);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule